// File: doc/BRIEF.md
# Descriptor Queue Engine with Doorbell

This block is the hardware front end of a command queue. The host stores fixed-size 512-bit work descriptors into a circular ring, moves a producer tail register forward, and then strikes a doorbell. Only the doorbell makes the committed descriptors visible to the engine. An internal worker takes the published descriptors one at a time and holds each one for a fixed number of decode cycles, which stand in for the real work. It then pushes one completion record per descriptor into a small completion queue, and the host drains that queue over a ready/valid port.

The host owns the tail and the engine owns the head. The head is exported so that the host can compute occupancy and reuse slots. Both indices carry one extra wrap bit, which lets a full ring be told apart from an empty one. A single tail commit followed by a single doorbell can publish a whole batch of descriptors. When the completion queue is full, the worker waits and nothing already queued is lost. Every push attempt that finds the queue full increments a counter the host can read.

Top module: `cmdq_engine`

## Requirements
- R1: Descriptor layout: bits [15:0] tag, [23:16] batch size, [31:24] index within batch, bit 32 reward request; other bits are payload and do not affect the completion. The completion word is {reward(32), index[31:24], size[23:16], tag[15:0]}, copied from the descriptor.
- R2: `head_o` is a wrap-bit index (width log2(DEPTH)+1) advanced only by the engine, one step per descriptor consumed, wrapping modulo 2*DEPTH; a ring holding exactly DEPTH published descriptors is accepted and fully drained.
- R3: Writing slots or the tail alone starts nothing; after a doorbell the engine consumes only slots below the tail value latched by that doorbell, so head never passes it.
- R4: A batch committed with one tail write and one doorbell yields one completion per descriptor, in slot order, each carrying its batch size and batch index.
- R5: With the completion queue full, the worker stalls without fetching further descriptors and without overwriting; after draining, every completion emerges in order with none lost; a presented completion holds stable until accepted.
- R6: The overflow counter `ovf_cnt_o` rises by exactly one for each cycle in which a ready completion finds the queue full, saturating at all ones, and is otherwise unchanged.
- R7: The completion outcome bit (bit 32) is 1 (reward needed) when the descriptor's reward bit is set, else 0 (done).
- R8: A doorbell whose latched tail is not 1..DEPTH ahead of the head (equal, or more than DEPTH ahead) is ignored: no descriptor is consumed and the head does not move.
- R9: From idle with an empty queue, `cpl_valid_o` rises exactly DECODE_CYCLES+3 clock edges after the edge that accepts the doorbell.
- R10: After reset, `head_o` is 0, `cpl_valid_o` is 0 and `ovf_cnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| desc_we_i | input | 1 | Descriptor slot write strobe |
| desc_idx_i | input | log2(DEPTH) | Slot written |
| desc_data_i | input | DESC_W | Descriptor contents |
| tail_we_i | input | 1 | Producer tail commit strobe |
| tail_i | input | log2(DEPTH)+1 | New producer tail, with wrap bit |
| doorbell_i | input | 1 | Doorbell write; publishes the committed tail |
| head_o | output | log2(DEPTH)+1 | Consumer head, with wrap bit |
| cpl_valid_o | output | 1 | Completion available |
| cpl_ready_i | input | 1 | Host accepts the completion |
| cpl_data_o | output | 33 | Completion record |
| ovf_cnt_o | output | OVF_W | Count of push attempts that found the queue full |

## Verification
The bench builds the engine with an 8-slot ring, a 2-entry completion queue and 3 decode cycles. With the small ring, one pass of a full batch wraps the head past its wrap bit, and a request 9 ahead of the head exercises the rejected doorbell. With two completion entries, the queue fills after two descriptors, so the third one stalls in the worker, and the overflow counter can be watched climbing one step per cycle. With a short decode latency, the exact doorbell-to-completion cycle count stays small enough to check edge by edge.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int TAG_W = 16;
  localparam int BCNT_W = 8;

  // field order matches the low descriptor bits, so the record is a direct copy
  typedef struct packed {
    logic              reward;
    logic [BCNT_W-1:0] bidx;
    logic [BCNT_W-1:0] bsize;
    logic [TAG_W-1:0]  tag;
  } cpl_rec_t;

  localparam int CPL_W = $bits(cpl_rec_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_POST,
    ST_STALL
  } wk_state_e;
endpackage

// File: rtl/cmdq_desc_ring.sv
module cmdq_desc_ring #(
  parameter int DEPTH  = 16,
  parameter int DESC_W = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [DESC_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [DESC_W-1:0] rdata_o
);
  logic [DESC_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cmdq_cpl_fifo.sv
module cmdq_cpl_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 33,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rp_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = valid_o && ready_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wp_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overwrite_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  assert_hold_until_taken_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/cmdq_worker.sv
module cmdq_worker
  import cmdq_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int DECODE_CYCLES = 8,
  parameter int OVF_W         = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1,
  localparam int CNT_W = $clog2(DECODE_CYCLES) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PTR_W-1:0] tail_i,
  input  logic             db_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [CPL_W-1:0] rd_rec_i,
  input  logic             cpl_full_i,
  output logic             cpl_push_o,
  output logic [CPL_W-1:0] cpl_rec_o,
  output logic [PTR_W-1:0] head_o,
  output logic [OVF_W-1:0] ovf_cnt_o
);
  wk_state_e        state_q;
  logic [PTR_W-1:0] head_q, pub_q, fill;
  logic [CNT_W-1:0] cnt_q;
  cpl_rec_t         rec_q;
  logic [OVF_W-1:0] ovf_q;
  logic             db_ok, pending, posting;

  // doorbell accepted only if the tail is 1..DEPTH slots ahead
  assign fill    = tail_i - head_q;
  assign db_ok   = db_i && (fill != '0) && (fill <= PTR_W'(DEPTH));
  assign pending = (pub_q != head_q);
  assign posting = (state_q == ST_POST) || (state_q == ST_STALL);

  assign rd_idx_o   = head_q[IDX_W-1:0];
  assign cpl_push_o = posting && !cpl_full_i;
  assign cpl_rec_o  = rec_q;
  assign head_o     = head_q;
  assign ovf_cnt_o  = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      head_q  <= '0;
      pub_q   <= '0;
      cnt_q   <= '0;
      rec_q   <= '0;
      ovf_q   <= '0;
    end else begin
      if (db_ok) pub_q <= tail_i;
      case (state_q)
        ST_IDLE: if (pending) state_q <= ST_FETCH;
        ST_FETCH: begin
          rec_q   <= cpl_rec_t'(rd_rec_i);
          head_q  <= head_q + 1'b1;
          cnt_q   <= CNT_W'(DECODE_CYCLES - 1);
          state_q <= ST_DECODE;
        end
        ST_DECODE: begin
          if (cnt_q == '0) state_q <= ST_POST;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_POST, ST_STALL: begin
          if (cpl_full_i) begin
            state_q <= ST_STALL;
            if (ovf_q != {OVF_W{1'b1}}) ovf_q <= ovf_q + 1'b1;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_head_within_pub_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pub_q - head_q) <= PTR_W'(DEPTH));

  assert_fetch_only_published_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FETCH) |-> pending);

  assert_ovf_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (posting && cpl_full_i && (ovf_q != {OVF_W{1'b1}})) |=> (ovf_q == $past(ovf_q) + 1'b1));

  assert_ovf_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(posting && cpl_full_i) |=> $stable(ovf_q));

  assert_stall_holds_head_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STALL) |=> $stable(head_q));

  assert_bad_db_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !pending && !db_ok) |=> (state_q == ST_IDLE));

  assert_decode_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DECODE && cnt_q != '0) |=> (state_q == ST_DECODE));
endmodule

// File: rtl/cmdq_engine.sv
module cmdq_engine
  import cmdq_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int CPL_DEPTH     = 8,
  parameter int DECODE_CYCLES = 8,
  parameter int DESC_W        = 512,
  parameter int OVF_W         = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              desc_we_i,
  input  logic [IDX_W-1:0]  desc_idx_i,
  input  logic [DESC_W-1:0] desc_data_i,
  input  logic              tail_we_i,
  input  logic [PTR_W-1:0]  tail_i,
  input  logic              doorbell_i,
  output logic [PTR_W-1:0]  head_o,
  output logic              cpl_valid_o,
  input  logic              cpl_ready_i,
  output logic [CPL_W-1:0]  cpl_data_o,
  output logic [OVF_W-1:0]  ovf_cnt_o
);
  logic [PTR_W-1:0]  tail_q;
  logic [IDX_W-1:0]  rd_idx;
  logic [DESC_W-1:0] rd_desc;
  logic [CPL_W-1:0]  wk_rec;
  logic              cpl_full, cpl_push;
  logic              unused_payload;

  // producer-owned tail
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tail_q <= '0;
    else if (tail_we_i) tail_q <= tail_i;
  end

  cmdq_desc_ring #(.DEPTH(DEPTH), .DESC_W(DESC_W)) u_ring (
    .clk_i  (clk_i),
    .we_i   (desc_we_i),
    .waddr_i(desc_idx_i),
    .wdata_i(desc_data_i),
    .raddr_i(rd_idx),
    .rdata_o(rd_desc)
  );

  assign unused_payload = ^rd_desc[DESC_W-1:CPL_W];

  cmdq_worker #(.DEPTH(DEPTH), .DECODE_CYCLES(DECODE_CYCLES), .OVF_W(OVF_W)) u_worker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tail_i    (tail_q),
    .db_i      (doorbell_i),
    .rd_idx_o  (rd_idx),
    .rd_rec_i  (rd_desc[CPL_W-1:0]),
    .cpl_full_i(cpl_full),
    .cpl_push_o(cpl_push),
    .cpl_rec_o (wk_rec),
    .head_o    (head_o),
    .ovf_cnt_o (ovf_cnt_o)
  );

  cmdq_cpl_fifo #(.DEPTH(CPL_DEPTH), .W(CPL_W)) u_cpl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (cpl_push),
    .data_i (wk_rec),
    .full_o (cpl_full),
    .valid_o(cpl_valid_o),
    .ready_i(cpl_ready_i),
    .data_o (cpl_data_o)
  );

  assert_head_one_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (head_o != $past(head_o)) |-> (head_o == $past(head_o) + 1'b1));
endmodule

// File: tb/cmdq_engine_tb.sv
module cmdq_engine_tb;
  localparam int DEPTH = 8;
  localparam int CPLD  = 2;
  localparam int DEC   = 3;
  localparam int DW    = 512;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          desc_we_i = 1'b0;
  logic [2:0]    desc_idx_i = '0;
  logic [DW-1:0] desc_data_i = '0;
  logic          tail_we_i = 1'b0;
  logic [3:0]    tail_i = '0;
  logic          doorbell_i = 1'b0;
  logic [3:0]    head_o;
  logic          cpl_valid_o;
  logic          cpl_ready_i = 1'b1;
  logic [32:0]   cpl_data_o;
  logic [15:0]   ovf_cnt_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done_flag = 0;
  logic [3:0] model_pub = '0;
  logic [3:0] host_tail = '0;
  logic [32:0] exp_q[$];

  always #10 clk = ~clk;

  cmdq_engine #(.DEPTH(DEPTH), .CPL_DEPTH(CPLD), .DECODE_CYCLES(DEC), .DESC_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .desc_we_i(desc_we_i), .desc_idx_i(desc_idx_i),
    .desc_data_i(desc_data_i), .tail_we_i(tail_we_i), .tail_i(tail_i),
    .doorbell_i(doorbell_i), .head_o(head_o), .cpl_valid_o(cpl_valid_o),
    .cpl_ready_i(cpl_ready_i), .cpl_data_o(cpl_data_o), .ovf_cnt_o(ovf_cnt_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done_flag) begin
      chk(0, "watchdog", cyc, 20000);
      finish_run();
    end
  end

  // per-clock reference: bound on head, completion stream in publish order
  always begin
    @(negedge clk); #8;
    if (rst_ni && !done_flag) begin
      logic [3:0] gap;
      gap = model_pub - head_o;
      chk(gap <= 4'(DEPTH), "R3 head beyond published tail", gap, DEPTH);
      if (cpl_valid_o && cpl_ready_i) begin
        if (exp_q.size() == 0) chk(0, "R5 unexpected completion", cpl_data_o, 0);
        else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          chk(cpl_data_o == e, "R1 R4 R7 completion record", cpl_data_o, e);
        end
      end
    end
  end

  task automatic put_desc(input logic [2:0] slot, input logic [15:0] tag,
                          input logic [7:0] bsize, input logic [7:0] bidx, input bit rwd);
    logic [DW-1:0] d;
    d = '1;
    d[32:0] = {rwd, bidx, bsize, tag};
    @(negedge clk);
    desc_we_i = 1'b1; desc_idx_i = slot; desc_data_i = d;
    @(negedge clk);
    desc_we_i = 1'b0;
    exp_q.push_back({rwd, bidx, bsize, tag});
  endtask

  task automatic commit(input logic [3:0] t);
    @(negedge clk);
    tail_we_i = 1'b1; tail_i = t;
    @(negedge clk);
    tail_we_i = 1'b0;
    host_tail = t;
  endtask

  task automatic ring_db(input bit accepted);
    @(negedge clk);
    doorbell_i = 1'b1;
    @(negedge clk);
    doorbell_i = 1'b0;
    if (accepted) model_pub = host_tail;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || cpl_valid_o) @(negedge clk);
    idle(2);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    @(negedge clk); #8;
    chk(head_o == 0, "R10 head after reset", head_o, 0);
    chk(cpl_valid_o == 0, "R10 valid after reset", cpl_valid_o, 0);
    chk(ovf_cnt_o == 0, "R10 ovf after reset", ovf_cnt_o, 0);

    // R3: slot write and tail commit without doorbell start nothing
    put_desc(3'd0, 16'hA001, 8'd1, 8'd0, 1'b0);
    commit(4'd1);
    idle(20); #8;
    chk(head_o == 0, "R3 no doorbell head", head_o, 0);
    chk(cpl_valid_o == 0, "R3 no doorbell valid", cpl_valid_o, 0);

    // R9: exact latency from accepted doorbell
    ring_db(1);
    repeat (DEC + 2) @(negedge clk);
    #8;
    chk(cpl_valid_o == 0, "R9 valid too early", cpl_valid_o, 0);
    @(negedge clk); #8;
    chk(cpl_valid_o == 1, "R9 valid at latency", cpl_valid_o, 1);
    drain();
    chk(head_o == 1, "R2 head after one", head_o, 1);

    // R8: doorbell with tail equal to head
    ring_db(0);
    idle(20); #8;
    chk(head_o == 1, "R8 equal tail head", head_o, 1);
    chk(cpl_valid_o == 0, "R8 equal tail valid", cpl_valid_o, 0);
    // R8: tail DEPTH+1 ahead
    commit(4'd10);
    ring_db(0);
    idle(20); #8;
    chk(head_o == 1, "R8 over-depth tail head", head_o, 1);
    chk(cpl_valid_o == 0, "R8 over-depth tail valid", cpl_valid_o, 0);

    // R4 R7: batch of four, one commit, one doorbell
    for (int i = 0; i < 4; i++)
      put_desc(3'(1 + i), 16'hB000 + 16'(i), 8'd4, 8'(i), i == 3);
    commit(4'd5);
    ring_db(1);
    drain();
    chk(head_o == 5, "R4 batch consumed", head_o, 5);

    // R5 R6: completion queue full, worker stalls
    cpl_ready_i = 1'b0;
    for (int i = 0; i < 4; i++)
      put_desc(3'(5 + i), 16'hC000 + 16'(i), 8'd4, 8'(i), i == 1);
    commit(4'd9);
    ring_db(1);
    idle(40); #8;
    chk(head_o == 8, "R5 stalled head", head_o, 8);
    chk(cpl_valid_o == 1, "R5 queue holds data", cpl_valid_o, 1);
    begin
      logic [15:0] a, b;
      a = ovf_cnt_o;
      idle(10); #8;
      b = ovf_cnt_o;
      chk(a != 0, "R6 ovf counted", a, 1);
      chk(b == a + 16'd10, "R6 ovf per cycle", b, a + 16'd10);
      chk(head_o == 8, "R5 head held in stall", head_o, 8);
    end
    @(negedge clk);
    cpl_ready_i = 1'b1;
    drain();
    chk(head_o == 9, "R2 head wrap bit", head_o, 9);
    begin
      logic [15:0] c;
      c = ovf_cnt_o;
      idle(10); #8;
      chk(ovf_cnt_o == c, "R6 ovf quiet", ovf_cnt_o, c);
    end

    // R2: exactly DEPTH published at once
    for (int i = 0; i < DEPTH; i++)
      put_desc(3'(1 + i), 16'hD000 + 16'(i), 8'(DEPTH), 8'(i), i[0]);
    commit(4'd1);
    ring_db(1);
    drain();
    chk(head_o == 1, "R2 full ring drained", head_o, 1);
    chk(exp_q.size() == 0, "R5 nothing lost", exp_q.size(), 0);

    finish_run();
  end
endmodule